// File: doc/BRIEF.md
# Standby Fault Sequencer

This block sequences the standby-side power domain through four states: Normal, Restart, Faulted Standby and Reset Standby. It watches four causes: a reset request, a supply-good indication, a power button and a thermal alarm. The button and the thermal alarm count only after they have been held long enough. The button limit is fixed at build time. The thermal limit is a run-time input. Both limits are counted in ticks of an external timebase.

Each cause that takes effect leaves a sticky flag at a fixed bit of a flags vector. Software clears a flag by writing a one to it. The block also drives two enables: one for working power and one for standby power.

Whether a cause applies depends on two things. The first is the system's present working state, which is Working, Sleep or Standby. The second is the sequencer's own state. When several causes arrive together, the reset request wins the state choice, and every cause that applies is still flagged. A restart request moves the machine out of either standby state into Restart. Dropping that request then returns it to Normal.

Top module: `stby_fault_seq`

## Requirements
- R1: After power-on reset, `state_o` is Normal (encoding 0: Normal, 1: Restart, 2: Faulted Standby, 3: Reset Standby), `flags_o` is all zero, and both power enables are 1.
- R2: A reset request that applies moves the state to Reset Standby (3) at the next edge and sets flag bit 0. In Reset Standby both `work_pwr_en_o` and `stby_pwr_en_o` are 0.
- R3: `vdd_ok_i` low, when it applies, moves the state to Faulted Standby (2) and sets flag bit 2. In Faulted Standby `work_pwr_en_o` is 0 and `stby_pwr_en_o` is 1.
- R4: `btn_i` held with `btn_en_i` high for BTN_HOLD timebase ticks, when it applies, moves the state to Faulted Standby and sets flag bit 3. With `btn_en_i` low the button has no effect.
- R5: `therm_i` held with `therm_en_i` high for `therm_hold_i` ticks, when the working state is not Standby, moves the state to Faulted Standby and sets flag bit 4.
- R6: A hold count restarts from zero whenever its input (or its enable) drops before the limit is reached. A limit is therefore met only by an unbroken hold.
- R7: Standby is signalled by `pwr_state_i[1]` = 1 (0: Working, 1: Sleep). In Standby, four rules apply. The reset request acts in Normal, Restart and Faulted Standby. `vdd_ok_i` low acts only in Restart. The button acts only in Normal or Restart. The thermal alarm is ignored. Outside Standby every cause acts in every state.
- R8: When the reset request and a fault cause act in the same cycle, the state becomes Reset Standby. The flag bit of every cause that acts is set.
- R9: Flags are sticky until `flag_clr_i` has a one at that bit. A set in the same cycle wins over a clear. Bit 1 always reads 0.
- R10: In Faulted Standby or Reset Standby, with no cause acting, `restart_i` high moves the state to Restart, where both enables are 1. In Restart, `restart_i` low with no cause acting moves the state to Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | Timebase tick for the hold counters |
| pwr_state_i | input | 2 | Working state: 0 Working, 1 Sleep, 2 or 3 Standby |
| rst_req_i | input | 1 | Reset-standby request, active high |
| vdd_ok_i | input | 1 | Supply good; low means low voltage |
| btn_i | input | 1 | Power button pressed, active high |
| btn_en_i | input | 1 | Enables the button fail-safe |
| therm_i | input | 1 | Thermal alarm, active high |
| therm_en_i | input | 1 | Enables the thermal shutdown |
| therm_hold_i | input | TW | Thermal hold limit in ticks |
| restart_i | input | 1 | Restart request |
| flag_clr_i | input | FLAG_W | Write-one-to-clear strobe for the flags |
| state_o | output | 2 | Sequencer state |
| work_pwr_en_o | output | 1 | Working power enable |
| stby_pwr_en_o | output | 1 | Standby power enable |
| flags_o | output | FLAG_W | Sticky cause flags (bits 0, 2, 3, 4) |

## Verification
Assertions check several rules on every cycle. A new reset flag always coincides with Reset Standby. A new voltage or button flag always comes with working power removed. A thermal flag never rises across a Standby cycle. Flags stay set until their clear bit is written. Hold counters drop to zero as soon as their input falls.

Some behaviour shows only in the bench scenarios. These cover the hold lengths themselves, the per-state standby rules for the voltage and button causes, the reset-over-fault priority and the restart exits. The bench compares each of them cycle by cycle against a behavioural model.

// File: rtl/stby_pkg.sv
package stby_pkg;

   typedef enum logic [1:0] {
      ST_NORMAL  = 2'd0,
      ST_RESTART = 2'd1,
      ST_FAULT   = 2'd2,
      ST_RSTSTBY = 2'd3
   } stby_state_e;

   localparam int unsigned FB_RESET   = 0;
   localparam int unsigned FB_LVD     = 2;
   localparam int unsigned FB_BTN     = 3;
   localparam int unsigned FB_THERM   = 4;
   localparam int unsigned FLAG_MIN_W = 5;

endpackage

// File: rtl/stby_hold_cnt.sv
module stby_hold_cnt #(
   parameter int unsigned CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic          in_i,
   input  logic [CW-1:0] limit_i,
   output logic          held_o
);

   logic [CW-1:0] cnt_q;

   generate
      if (CW < 1) begin : g_bad_width
         $error("stby_hold_cnt: CW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (!in_i)
         cnt_q <= '0;
      else if (tick_i && (cnt_q < limit_i))
         cnt_q <= cnt_q + 1'b1;
   end

   assign held_o = in_i && (cnt_q >= limit_i);

   // R6: a dropped input restarts the count
   p_cnt_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_i |=> (cnt_q == '0));

   // R6: a hold can only be reported while the input is present
   p_held_needs_in_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      held_o |-> in_i);

endmodule

// File: rtl/stby_flag_reg.sv
module stby_flag_reg #(
   parameter int unsigned FLAG_W = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [FLAG_W-1:0] set_i,
   input  logic [FLAG_W-1:0] clr_i,
   output logic [FLAG_W-1:0] flags_o
);
   import stby_pkg::*;

   localparam logic [FLAG_W-1:0] LIVE_MASK =
      FLAG_W'((1 << FB_RESET) | (1 << FB_LVD) | (1 << FB_BTN) | (1 << FB_THERM));

   generate
      if (FLAG_W < FLAG_MIN_W) begin : g_bad_width
         $error("stby_flag_reg: FLAG_W too small for the cause bits");
      end
      for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
         if (LIVE_MASK[i]) begin : g_live
            logic flag_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni)
                  flag_q <= 1'b0;
               else if (set_i[i])
                  flag_q <= 1'b1;
               else if (clr_i[i])
                  flag_q <= 1'b0;
            end
            assign flags_o[i] = flag_q;

            // R9: a flag holds until its clear bit is written
            p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
               (flag_q && !clr_i[i]) |=> flag_q);
         end else begin : g_dead
            assign flags_o[i] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/stby_cause_arb.sv
module stby_cause_arb #(
   parameter int unsigned FLAG_W = 5
) (
   input  stby_pkg::stby_state_e state_i,
   input  logic                  in_stby_i,
   input  logic                  rst_req_i,
   input  logic                  vdd_ok_i,
   input  logic                  btn_held_i,
   input  logic                  therm_held_i,
   input  logic                  restart_i,
   output logic [FLAG_W-1:0]     set_o,
   output stby_pkg::stby_state_e state_d_o
);
   import stby_pkg::*;

   logic rst_act, lvd_act, btn_act, thm_act;

   always_comb begin
      rst_act = rst_req_i    && (!in_stby_i || (state_i != ST_RSTSTBY));
      lvd_act = !vdd_ok_i    && (!in_stby_i || (state_i == ST_RESTART));
      btn_act = btn_held_i   && (!in_stby_i || (state_i == ST_NORMAL) ||
                                 (state_i == ST_RESTART));
      thm_act = therm_held_i && !in_stby_i;

      set_o           = '0;
      set_o[FB_RESET] = rst_act;
      set_o[FB_LVD]   = lvd_act;
      set_o[FB_BTN]   = btn_act;
      set_o[FB_THERM] = thm_act;

      if (rst_act)
         state_d_o = ST_RSTSTBY;
      else if (lvd_act || btn_act || thm_act)
         state_d_o = ST_FAULT;
      else begin
         unique case (state_i)
            ST_FAULT, ST_RSTSTBY: state_d_o = restart_i ? ST_RESTART : state_i;
            ST_RESTART:           state_d_o = restart_i ? ST_RESTART : ST_NORMAL;
            default:              state_d_o = ST_NORMAL;
         endcase
      end
   end

endmodule

// File: rtl/stby_fault_seq.sv
module stby_fault_seq #(
   parameter int unsigned BTN_HOLD = 4000,
   parameter int unsigned TW       = 16,
   parameter int unsigned FLAG_W   = 5,
   localparam int unsigned BTN_CW  = $clog2(BTN_HOLD + 1) < 1 ? 1 : $clog2(BTN_HOLD + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [1:0]        pwr_state_i,
   input  logic              rst_req_i,
   input  logic              vdd_ok_i,
   input  logic              btn_i,
   input  logic              btn_en_i,
   input  logic              therm_i,
   input  logic              therm_en_i,
   input  logic [TW-1:0]     therm_hold_i,
   input  logic              restart_i,
   input  logic [FLAG_W-1:0] flag_clr_i,
   output logic [1:0]        state_o,
   output logic              work_pwr_en_o,
   output logic              stby_pwr_en_o,
   output logic [FLAG_W-1:0] flags_o
);
   import stby_pkg::*;

   localparam logic [BTN_CW-1:0] BTN_LIMIT = BTN_CW'(BTN_HOLD);

   generate
      if (TW < 1) begin : g_bad_tw
         $error("stby_fault_seq: TW must be at least 1");
      end
      if (FLAG_W < FLAG_MIN_W) begin : g_bad_fw
         $error("stby_fault_seq: FLAG_W too small");
      end
   endgenerate

   stby_state_e       state_q, state_d;
   logic              btn_held, therm_held;
   logic [FLAG_W-1:0] flag_set;

   stby_hold_cnt #(.CW(BTN_CW)) u_btn_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .in_i    (btn_i && btn_en_i),
      .limit_i (BTN_LIMIT),
      .held_o  (btn_held)
   );

   stby_hold_cnt #(.CW(TW)) u_therm_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .in_i    (therm_i && therm_en_i),
      .limit_i (therm_hold_i),
      .held_o  (therm_held)
   );

   stby_cause_arb #(.FLAG_W(FLAG_W)) u_arb (
      .state_i      (state_q),
      .in_stby_i    (pwr_state_i[1]),
      .rst_req_i    (rst_req_i),
      .vdd_ok_i     (vdd_ok_i),
      .btn_held_i   (btn_held),
      .therm_held_i (therm_held),
      .restart_i    (restart_i),
      .set_o        (flag_set),
      .state_d_o    (state_d)
   );

   stby_flag_reg #(.FLAG_W(FLAG_W)) u_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (flag_set),
      .clr_i   (flag_clr_i),
      .flags_o (flags_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         state_q <= ST_NORMAL;
      else
         state_q <= state_d;
   end

   assign state_o       = state_q;
   assign work_pwr_en_o = (state_q == ST_NORMAL) || (state_q == ST_RESTART);
   assign stby_pwr_en_o = (state_q != ST_RSTSTBY);

   // R2: a fresh reset flag always lands together with Reset Standby
   p_rst_flag_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_o[FB_RESET]) |-> (state_o == 2'd3));

   // R3: a fresh voltage flag always comes with working power removed
   p_lvd_flag_power_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_o[FB_LVD]) |-> !work_pwr_en_o);

   // R4: a fresh button flag always comes with working power removed
   p_btn_flag_power_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_o[FB_BTN]) |-> !work_pwr_en_o);

   // R7: thermal alarm never flags across a Standby cycle
   p_therm_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_state_i[1] |=> !$rose(flags_o[FB_THERM]));

endmodule

// File: tb/sim_stby_fault_seq.sv
`timescale 1ns/1ps
module sim_stby_fault_seq;

   localparam int BTN_HOLD = 5;
   localparam int TW       = 4;
   localparam int FW       = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [1:0]    pwr = 2'd0;
   logic          rst_req = 1'b0, vdd_ok = 1'b1;
   logic          btn = 1'b0, btn_en = 1'b1;
   logic          therm = 1'b0, therm_en = 1'b1;
   logic [TW-1:0] therm_hold = 4'd3;
   logic          restart = 1'b0;
   logic [FW-1:0] clr = '0;
   logic [1:0]    state;
   logic          work_en, stby_en;
   logic [FW-1:0] flags;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   stby_fault_seq #(.BTN_HOLD(BTN_HOLD), .TW(TW), .FLAG_W(FW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pwr_state_i(pwr),
      .rst_req_i(rst_req), .vdd_ok_i(vdd_ok), .btn_i(btn), .btn_en_i(btn_en),
      .therm_i(therm), .therm_en_i(therm_en), .therm_hold_i(therm_hold),
      .restart_i(restart), .flag_clr_i(clr), .state_o(state),
      .work_pwr_en_o(work_en), .stby_pwr_en_o(stby_en), .flags_o(flags)
   );

   // timebase: one tick every third cycle
   int tdiv = 0;
   always @(negedge clk) begin
      tdiv = (tdiv + 1) % 3;
      tick <= (tdiv == 0);
   end

   // behavioural reference model
   int m_st, m_fl, m_bc, m_tc;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_fl = 0; m_bc = 0; m_tc = 0;
      end else begin : step
         bit sb, bin, tin, bh, th, ra, la, ba, ta;
         int nst;
         sb  = pwr[1];
         bin = btn && btn_en;
         tin = therm && therm_en;
         bh  = bin && (m_bc >= BTN_HOLD);
         th  = tin && (m_tc >= int'(therm_hold));
         ra  = rst_req && (!sb || m_st != 3);
         la  = !vdd_ok && (!sb || m_st == 1);
         ba  = bh && (!sb || m_st <= 1);
         ta  = th && !sb;
         if (ra) nst = 3;
         else if (la || ba || ta) nst = 2;
         else if (m_st >= 2) nst = restart ? 1 : m_st;
         else if (m_st == 1) nst = restart ? 1 : 0;
         else nst = 0;
         m_fl = m_fl & ~int'(clr);
         if (ra) m_fl = m_fl | 1;
         if (la) m_fl = m_fl | 4;
         if (ba) m_fl = m_fl | 8;
         if (ta) m_fl = m_fl | 16;
         m_fl = m_fl & 'h1D;
         m_st = nst;
         if (!bin) m_bc = 0; else if (tick && m_bc < BTN_HOLD) m_bc++;
         if (!tin) m_tc = 0; else if (tick && m_tc < int'(therm_hold)) m_tc++;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk(cur_req, "model state", int'(state), m_st);
         chk(cur_req, "model flags", int'(flags), m_fl);
         chk(cur_req, "model work_en", int'(work_en), (m_st <= 1) ? 1 : 0);
         chk(cur_req, "model stby_en", int'(stby_en), (m_st != 3) ? 1 : 0);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic recover();
      restart = 1'b1; cyc(1);
      restart = 1'b0; cyc(1);
      clr = '1;       cyc(1);
      clr = '0;       cyc(1);
   endtask

   initial begin
      #100000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      cur_req = "R1";
      chk("R1", "reset state", state, 0);
      chk("R1", "reset flags", flags, 0);
      chk("R1", "reset work_en", work_en, 1);
      chk("R1", "reset stby_en", stby_en, 1);

      cur_req = "R6";
      btn = 1; cyc(6); btn = 0; cyc(2);
      chk("R6", "short press state", state, 0);
      chk("R6", "short press flags", flags, 0);
      btn = 1; cyc(9); btn = 0; cyc(1); btn = 1; cyc(9);
      chk("R6", "broken hold state", state, 0);

      cur_req = "R4";
      cyc(25);
      chk("R4", "button fault state", state, 2);
      chk("R4", "button flag", flags, 5'b01000);
      chk("R4", "button work_en", work_en, 0);
      btn = 0; cyc(1);

      cur_req = "R10";
      restart = 1; cyc(1);
      chk("R10", "restart state", state, 1);
      chk("R10", "restart work_en", work_en, 1);
      restart = 0; cyc(1);
      chk("R10", "back to normal", state, 0);

      cur_req = "R9";
      cyc(2);
      chk("R9", "sticky flag", flags, 5'b01000);
      clr = 5'b11111; cyc(1); clr = '0; cyc(1);
      chk("R9", "cleared flags", flags, 0);

      cur_req = "R4";
      btn_en = 0; btn = 1; cyc(30);
      chk("R4", "disabled button state", state, 0);
      chk("R4", "disabled button flags", flags, 0);
      btn = 0; btn_en = 1; cyc(1);

      cur_req = "R5";
      therm = 1; cyc(20);
      chk("R5", "thermal state", state, 2);
      chk("R5", "thermal flag", flags, 5'b10000);
      therm = 0; recover();

      cur_req = "R3";
      vdd_ok = 0; cyc(2);
      chk("R3", "lvd state", state, 2);
      chk("R3", "lvd flag", flags, 5'b00100);
      chk("R3", "lvd work_en", work_en, 0);
      chk("R3", "lvd stby_en", stby_en, 1);
      vdd_ok = 1; recover();

      cur_req = "R8";
      rst_req = 1; vdd_ok = 0; cyc(1);
      chk("R8", "priority state", state, 3);
      chk("R8", "both flags", flags, 5'b00101);
      chk("R2", "rststby work_en", work_en, 0);
      chk("R2", "rststby stby_en", stby_en, 0);
      rst_req = 0; vdd_ok = 1; recover();
      chk("R10", "recovered state", state, 0);
      chk("R9", "recovered flags", flags, 0);

      cur_req = "R7";
      pwr = 2'd2; cyc(1);
      vdd_ok = 0; cyc(3);
      chk("R7", "lvd ignored in normal standby", state, 0);
      chk("R7", "lvd no flag in normal standby", flags, 0);
      vdd_ok = 1; therm = 1; cyc(20);
      chk("R7", "thermal ignored in standby", flags, 0);
      therm = 0; btn = 1; cyc(30);
      chk("R7", "button in normal standby", state, 2);
      chk("R7", "button flag in standby", flags, 5'b01000);
      btn = 0; vdd_ok = 0; cyc(3);
      chk("R7", "lvd ignored in faulted standby", flags, 5'b01000);
      vdd_ok = 1; rst_req = 1; cyc(2);
      chk("R7", "reset in faulted standby", state, 3);
      chk("R2", "reset flag", flags, 5'b01001);
      rst_req = 0; restart = 1; cyc(2);
      chk("R10", "restart from rststby", state, 1);
      restart = 0; vdd_ok = 0; cyc(1);
      chk("R7", "lvd acts in restart", state, 2);
      chk("R7", "lvd flag in restart", flags, 5'b01101);
      vdd_ok = 1; pwr = 2'd0; recover();

      cur_req = "R9";
      restart = 0; vdd_ok = 0; clr = 5'b00110; cyc(1);
      clr = '0; vdd_ok = 1; cyc(1);
      chk("R9", "set beats clear", flags, 5'b00100);
      chk("R9", "bit1 reads zero", int'(flags[1]), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule